// File: doc/BRIEF.md
# Processor Bus Address Decoder with Access Trap

This block sits on a 32-bit processor bus and sorts each access into one of four classes: boot ROM, main RAM, the 256-byte control-register window, or nothing. An access that lands in nothing is answered with a trap flag, and its address is latched for the fault handler. How much of the ROM and RAM space counts as present is set at run time by two size codes in a configuration word inside the control window. Out of reset the block decodes only a small part of each region, so boot code must widen the sizes before it uses more memory.

The control window holds three kinds of word. The first is a control word, whose only live bit enables address protection. The second is the size configuration word. Every other word offset in the window is plain scratch storage: a write there is kept and reads back, and has no other effect. The memory arrays, wait states and the protection checks are outside this block.

Requests arrive on a valid/ready stream, and results leave on a second valid/ready stream through a single registered stage. `req_ready` is high whenever the output slot is empty or is being emptied in the same cycle. Once a response is offered, it stays unchanged until `resp_ready` takes it. A request and its response never appear on the same edge.

Top module: `bus_addr_decoder`

## Requirements
- R1: After reset, `resp_valid` is 0, `req_ready` is 1, `prot_en` is 0 and `fault_addr` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and its response is offered from that edge on. `req_ready` equals `!resp_valid || resp_ready`. While `resp_valid` is high and `resp_ready` is low, every response output holds its value and no new request is accepted.
- R3: An address below 0x00000000 + (4 KB << PSIZ) is reported with region code 0 (ROM) and no trap. The ROM size saturates at 512 KB, so 0x00080000 and above are never ROM.
- R4: An address from 0x02000000 up to, but not including, 0x02000000 + (256 KB << RSIZ) is reported with region code 1 (RAM) and no trap. The RAM size saturates at 4 MB, so 0x02400000 and above are never RAM.
- R5: Every address from 0x01F80000 to 0x01F800FF is reported with region code 2 (control window) and never traps.
- R6: Any other address is reported with region code 3 and `resp_trap` high. `fault_addr` takes that address on the acceptance edge.
- R7: The word at window offset 0x10 is the size configuration. RSIZ is bits [4:2] and PSIZ is bits [10:8]. All other bits are dropped and read as 0.
- R8: Reset leaves RSIZ and PSIZ at 0, which decodes 4 KB of ROM and 256 KB of RAM.
- R9: The word at window offset 0x00 keeps only bit 3, which drives `prot_en`. Its other bits read as 0.
- R10: Every other word offset in the window stores the full 32 bits written and returns them on a read. Such a write changes neither `prot_en` nor the decoded sizes.
- R11: A window write affects only requests accepted on later edges. `resp_rdata` carries the stored word for window reads and is 0 for writes and for every other region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response offered |
| resp_ready | input | 1 | Downstream takes the response |
| resp_region | output | 2 | 0 ROM, 1 RAM, 2 control window, 3 none |
| resp_trap | output | 1 | Memory exception for this access |
| resp_rdata | output | 32 | Window read data, otherwise 0 |
| prot_en | output | 1 | Address protection enable |
| fault_addr | output | 32 | Address of the most recent trapped access |

## Verification
Every result of an accepted request is due exactly one edge after acceptance. This covers the region, the trap, the read data, the fault address and any change to a window word or to `prot_en`. The bench drives inputs on falling edges and reads outputs on the falling edge that follows the acceptance edge, so it never samples a value that is still changing. The back-pressure test holds `resp_ready` low across several edges and checks that the response stays the same and that a second request waits. When `resp_ready` goes high, the waiting request is accepted on that same edge, and the bench reads its response half a cycle later.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    RG_ROM  = 2'd0,
    RG_RAM  = 2'd1,
    RG_CTRL = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  // word indices inside the control window
  localparam int CTL_WORD_IDX = 0;
  localparam int CFG_WORD_IDX = 4;
  // live bit and field positions
  localparam int PROT_BIT   = 3;
  localparam int RSZ_LSB    = 2;
  localparam int PSZ_LSB    = 8;
  localparam int SZ_CODE_W  = 3;
endpackage

// File: rtl/abd_size_decode.sv
module abd_size_decode #(
  parameter int MIN_LG = 12,
  parameter int MAX_LG = 19
) (
  input  logic [abd_pkg::SZ_CODE_W-1:0] code,
  output logic [5:0]                    lg
);
  logic [5:0] sum;
  always_comb begin
    sum = 6'(MIN_LG) + 6'(code);
    lg  = (sum > 6'(MAX_LG)) ? 6'(MAX_LG) : sum;
  end
endmodule

// File: rtl/abd_classify.sv
module abd_classify
  import abd_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] ROM_BASE   = 32'h0000_0000,
  parameter logic [31:0] RAM_BASE   = 32'h0200_0000,
  parameter logic [31:0] CTRL_BASE  = 32'h01F8_0000,
  parameter int          CTRL_LG    = 8,
  parameter int          ROM_MAX_LG = 19,
  parameter int          RAM_MAX_LG = 22
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [5:0]        rom_lg,
  input  logic [5:0]        ram_lg,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] ROM_B = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] RAM_B = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] CTL_B = ADDR_W'(CTRL_BASE);

  logic [ADDR_W-1:0] rom_off, ram_off;
  logic rom_hit, ram_hit, ctl_hit;

  always_comb begin
    rom_off = addr - ROM_B;
    ram_off = addr - RAM_B;
    rom_hit = (addr >= ROM_B) && ((rom_off >> rom_lg) == '0);
    ram_hit = (addr >= RAM_B) && ((ram_off >> ram_lg) == '0);
    ctl_hit = (addr[ADDR_W-1:CTRL_LG] == CTL_B[ADDR_W-1:CTRL_LG]);
    if (ctl_hit)      region = RG_CTRL;
    else if (rom_hit) region = RG_ROM;
    else if (ram_hit) region = RG_RAM;
    else              region = RG_NONE;
  end

  always_comb begin
    if (region == RG_ROM)
      assert_rom_bound_R3: assert ((addr - ROM_B) < (ADDR_W'(1) << ROM_MAX_LG));
    if (region == RG_RAM)
      assert_ram_bound_R4: assert ((addr - RAM_B) < (ADDR_W'(1) << RAM_MAX_LG));
  end
endmodule

// File: rtl/abd_regfile.sv
module abd_regfile
  import abd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 prot_en,
  output logic [SZ_CODE_W-1:0] rsize,
  output logic [SZ_CODE_W-1:0] psize
);
  localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'(1) << PROT_BIT;
  localparam logic [DATA_W-1:0] CFG_MASK =
    (DATA_W'((1 << SZ_CODE_W) - 1) << RSZ_LSB) |
    (DATA_W'((1 << SZ_CODE_W) - 1) << PSZ_LSB);

  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] MASK =
      (w == CTL_WORD_IDX) ? CTL_MASK :
      (w == CFG_WORD_IDX) ? CFG_MASK : '1;
    always_ff @(posedge clk) begin
      if (!rst_n)                          words[w] <= '0;
      else if (wr_en && idx == IDX_W'(w))  words[w] <= wdata & MASK;
    end
  end

  assign rdata   = words[idx];
  assign prot_en = words[CTL_WORD_IDX][PROT_BIT];
  assign rsize   = words[CFG_WORD_IDX][RSZ_LSB +: SZ_CODE_W];
  assign psize   = words[CFG_WORD_IDX][PSZ_LSB +: SZ_CODE_W];

  assert_prot_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_en) |-> $past(wr_en && idx == IDX_W'(CTL_WORD_IDX)));
  assert_size_only_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(rsize) && $stable(psize)) |-> $past(wr_en && idx == IDX_W'(CFG_WORD_IDX)));
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import abd_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          CTRL_WORDS = 64,
  parameter logic [31:0] ROM_BASE   = 32'h0000_0000,
  parameter logic [31:0] RAM_BASE   = 32'h0200_0000,
  parameter logic [31:0] CTRL_BASE  = 32'h01F8_0000,
  parameter int          ROM_MIN_LG = 12,
  parameter int          ROM_MAX_LG = 19,
  parameter int          RAM_MIN_LG = 18,
  parameter int          RAM_MAX_LG = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [1:0]        resp_region,
  output logic              resp_trap,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              prot_en,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int IDX_W   = $clog2(CTRL_WORDS);
  localparam int CTRL_LG = IDX_W + 2;

  logic [5:0] rom_lg, ram_lg;
  logic [SZ_CODE_W-1:0] rsize, psize;
  region_e region;
  logic [DATA_W-1:0] win_rdata;
  logic acc, win_wr;

  assign req_ready = !resp_valid || resp_ready;
  assign acc       = req_valid && req_ready;
  assign win_wr    = acc && req_write && (region == RG_CTRL);

  abd_size_decode #(.MIN_LG(ROM_MIN_LG), .MAX_LG(ROM_MAX_LG)) i_rom_sz (
    .code(psize), .lg(rom_lg));
  abd_size_decode #(.MIN_LG(RAM_MIN_LG), .MAX_LG(RAM_MAX_LG)) i_ram_sz (
    .code(rsize), .lg(ram_lg));

  abd_classify #(
    .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .RAM_BASE(RAM_BASE),
    .CTRL_BASE(CTRL_BASE), .CTRL_LG(CTRL_LG),
    .ROM_MAX_LG(ROM_MAX_LG), .RAM_MAX_LG(RAM_MAX_LG)
  ) i_cls (
    .addr(req_addr), .rom_lg(rom_lg), .ram_lg(ram_lg), .region(region));

  abd_regfile #(.DATA_W(DATA_W), .WORDS(CTRL_WORDS)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr),
    .idx(req_addr[CTRL_LG-1:2]), .wdata(req_wdata), .rdata(win_rdata),
    .prot_en(prot_en), .rsize(rsize), .psize(psize));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_region <= 2'(RG_NONE);
      resp_trap   <= 1'b0;
      resp_rdata  <= '0;
      fault_addr  <= '0;
    end else begin
      if (acc) begin
        resp_valid  <= 1'b1;
        resp_region <= 2'(region);
        resp_trap   <= (region == RG_NONE);
        resp_rdata  <= (region == RG_CTRL && !req_write) ? win_rdata : '0;
        if (region == RG_NONE) fault_addr <= req_addr;
      end else if (resp_ready) begin
        resp_valid  <= 1'b0;
      end
    end
  end

  assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_region)
      && $stable(resp_trap) && $stable(resp_rdata));
  assert_trap_means_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_trap == (resp_region == 2'(RG_NONE))));
  assert_fault_addr_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> $past(acc));
  assert_window_never_traps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_region == 2'(RG_CTRL) |-> !resp_trap);
endmodule

// File: tb/test_bus_addr_decoder.sv
`timescale 1ns/1ps
module test_bus_addr_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid, resp_trap, prot_en;
  logic [1:0] resp_region;
  logic [31:0] resp_rdata, fault_addr;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bus_addr_decoder i_bus_addr_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_region(resp_region),
    .resp_trap(resp_trap), .resp_rdata(resp_rdata), .prot_en(prot_en),
    .fault_addr(fault_addr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access, response sampled half a cycle after acceptance
  task automatic access(logic [31:0] a, logic wr, logic [31:0] d);
    @(negedge clk);
    req_addr = a; req_write = wr; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_region(string req, logic [31:0] a, logic [1:0] rg);
    access(a, 1'b0, '0);
    check(req, {30'd0, resp_region}, {30'd0, rg});
    check(req, {31'd0, resp_trap}, {31'd0, rg == 2'd3});
    if (rg == 2'd3) check(req, fault_addr, a);
  endtask

  task automatic t_reset;
    check("R1", {31'd0, resp_valid}, 0);
    check("R1", {31'd0, req_ready}, 1);
    check("R1", {31'd0, prot_en}, 0);
    check("R1", fault_addr, 0);
  endtask

  task automatic t_default_sizes;
    expect_region("R8", 32'h0000_0FFC, 2'd0);
    expect_region("R8", 32'h0000_1000, 2'd3);
    expect_region("R8", 32'h0203_FFFC, 2'd1);
    expect_region("R8", 32'h0204_0000, 2'd3);
    expect_region("R4", 32'h01FF_FFFC, 2'd3);
  endtask

  task automatic t_window;
    expect_region("R5", 32'h01F8_0000, 2'd2);
    expect_region("R5", 32'h01F8_00FF, 2'd2);
    expect_region("R6", 32'h01F8_0100, 2'd3);
    expect_region("R6", 32'h01F7_FFFC, 2'd3);
    expect_region("R6", 32'hFFFF_FFF0, 2'd3);
  endtask

  task automatic t_control;
    access(32'h01F8_0000, 1'b1, 32'hFFFF_FFFF);
    check("R11", resp_rdata, 0);
    check("R9", {31'd0, prot_en}, 1);
    access(32'h01F8_0000, 1'b0, '0);
    check("R9", resp_rdata, 32'h0000_0008);
    access(32'h01F8_0000, 1'b1, 32'hFFFF_FFF7);
    check("R9", {31'd0, prot_en}, 0);
  endtask

  task automatic t_scratch;
    access(32'h01F8_0044, 1'b1, 32'hA5A5_5A5A);
    access(32'h01F8_00FC, 1'b1, 32'h1234_5678);
    check("R10", {31'd0, prot_en}, 0);
    access(32'h01F8_0044, 1'b0, '0);
    check("R10", resp_rdata, 32'hA5A5_5A5A);
    access(32'h01F8_00FC, 1'b0, '0);
    check("R10", resp_rdata, 32'h1234_5678);
    expect_region("R10", 32'h0000_1000, 2'd3);
    access(32'h0000_0100, 1'b0, '0);
    check("R11", resp_rdata, 0);
  endtask

  task automatic t_sizes;
    // RSIZ=2 -> 1 MB RAM, PSIZ=0, junk bits dropped
    access(32'h01F8_0010, 1'b1, 32'hFFFF_F8E3 | 32'h0000_0008);
    access(32'h01F8_0010, 1'b0, '0);
    check("R7", resp_rdata, 32'h0000_0008);
    expect_region("R4", 32'h020F_FFFC, 2'd1);
    expect_region("R4", 32'h0210_0000, 2'd3);
    // PSIZ=7, RSIZ=7 -> saturate at 512 KB / 4 MB
    access(32'h01F8_0010, 1'b1, 32'h0000_071C);
    expect_region("R3", 32'h0007_FFFC, 2'd0);
    expect_region("R3", 32'h0008_0000, 2'd3);
    expect_region("R4", 32'h023F_FFFC, 2'd1);
    expect_region("R4", 32'h0240_0000, 2'd3);
    // PSIZ=3 -> 32 KB ROM
    access(32'h01F8_0010, 1'b1, 32'h0000_0300);
    expect_region("R3", 32'h0000_7FFC, 2'd0);
    expect_region("R3", 32'h0000_8000, 2'd3);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    resp_ready = 1'b0;
    req_addr = 32'h0300_0000; req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2", {31'd0, resp_valid}, 1);
    check("R2", {31'd0, req_ready}, 0);
    req_addr = 32'h01F8_0044;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", {30'd0, resp_region}, 32'd3);
    check("R2", fault_addr, 32'h0300_0000);
    resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", {30'd0, resp_region}, 32'd2);
    check("R2", resp_rdata, 32'hA5A5_5A5A);
    @(posedge clk);
    @(negedge clk);
    check("R2", {31'd0, resp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_sizes();
    t_window();
    t_control();
    t_scratch();
    t_sizes();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule